// File: doc/BRIEF.md
# Pointer-Addressed Two-Wire Register Slave

This block is a slave on a two-wire serial bus (SCL clock, SDA data). It lets an external master reach a bank of byte-wide registers through one internal pointer. Both bus lines are brought into a faster system clock domain through synchronizers. The block finds START, repeated START and STOP conditions, checks a 7-bit device address, and pulls SDA low through an open-drain enable to acknowledge or to send read data.

A write operation always loads its first data byte into the pointer. An optional second byte is written to the register the pointer selects. To read, the master first writes the pointer and then, without a STOP, issues a repeated START and sends the address with the read bit set. The slave then returns the selected register. The pointer never advances by itself.

The register bank sits outside the block. The block gives a one-cycle write strobe with address and data. Its read address is the pointer, and the byte at that address comes back on a read-data input.

Top module: `ptr_reg_slave`

## Requirements
- R1: An address byte whose first seven bits (MSB first) equal DEV_ADDR (default 7'b0101110) is acknowledged: SDA is held low during the ninth SCL pulse. The eighth bit selects direction, 0 = write and 1 = read.
- R2: An address byte that does not match gets no acknowledge. Every later byte up to the next START is also left unacknowledged and causes no register write and no pointer change.
- R3: In a write operation the first data byte is acknowledged and stored in the pointer, which appears on reg_rd_addr.
- R4: A second data byte in the same write is acknowledged and produces exactly one single-cycle reg_wr_en pulse, with reg_wr_addr equal to the pointer and reg_wr_data equal to the byte.
- R5: A write carrying only one data byte changes the pointer and produces no reg_wr_en pulse.
- R6: Data bytes after the second byte of a write are acknowledged but cause no further write, and the pointer stays unchanged.
- R7: After a read address, the slave sends reg_rd_data for the current pointer, MSB first. sda_oe = 1 means SDA is pulled low, so a 1 bit is sent with sda_oe = 0.
- R8: If the master leaves SDA high on the ninth clock of a read byte (no acknowledge), the slave releases SDA and stays idle through the following STOP. If the master acknowledges, the same register is sent again and the pointer does not increment.
- R9: sda_oe changes only after a falling SCL edge, or at a START or STOP. It is stable while SCL is high.
- R10: A START or STOP at any point abandons the current byte, and a partial data byte writes nothing. A STOP releases SDA. A START returns the slave to address reception, so the next full address byte is acknowledged.
- R11: After reset, sda_oe is 0, reg_wr_en is 0 and the pointer is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen on the pin |
| sda_i | input | 1 | Bus data line as seen on the pin |
| sda_oe | output | 1 | 1 pulls SDA low; 0 releases it |
| reg_wr_en | output | 1 | Single-cycle register write strobe |
| reg_wr_addr | output | 8 | Register write address (the pointer) |
| reg_wr_data | output | 8 | Register write data |
| reg_rd_addr | output | 8 | Register read address (the pointer) |
| reg_rd_data | input | 8 | Contents of the register at reg_rd_addr |

## Verification
The checker assumes a well-behaved master. Every SCL high and low phase must last longer than the synchronizer and edge-detect delay of about four system clocks. SDA must change only while SCL is low, except when the master deliberately forms a START or STOP. The bench's bus model follows these rules: each quarter bit period is ten system clocks, data changes only in the SCL-low quarter, and START and STOP are the only SDA moves made while SCL is high. Under those conditions the rule that sda_oe changes only after a falling edge or a bus condition is meaningful. A glitchy or overly fast master would instead show up as false START/STOP detection.

// File: rtl/smb_ptr_pkg.sv
package smb_ptr_pkg;

    localparam int BYTE_W = 8;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_CHK,
        ST_ACK_A,
        ST_DATA,
        ST_DATA_END,
        ST_ACK_D,
        ST_TX,
        ST_TX_END,
        ST_MACK,
        ST_RELOAD
    } st_e;

    typedef struct packed {
        st_e               st;
        logic [2:0]        bitcnt;
        logic [BYTE_W-1:0] shreg;
        logic              rw;
        logic [1:0]        idx;
        logic [BYTE_W-1:0] ptr;
        logic              oe;
        logic              wr_en;
        logic [BYTE_W-1:0] wr_data;
    } fsm_s;

endpackage

// File: rtl/smb_sync.sv
module smb_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] r_q;

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) r_q[0] <= RST_VAL;
                else        r_q[0] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) r_q[g] <= RST_VAL;
                else        r_q[g] <= r_q[g-1];
            end
        end
    end

    assign q = r_q[STAGES-1];
endmodule

// File: rtl/smb_cond_det.sv
module smb_cond_det #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start,
    output logic stop
);
    logic scl_s;
    logic scl_q, sda_q;

    smb_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) scl_sync_i (
        .clk(clk), .rst_n(rst_n), .d(scl_i), .q(scl_s)
    );
    smb_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) sda_sync_i (
        .clk(clk), .rst_n(rst_n), .d(sda_i), .q(sda_s)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_s;
            sda_q <= sda_s;
        end
    end

    assign scl_rise = scl_s & ~scl_q;
    assign scl_fall = ~scl_s & scl_q;
    assign start    = scl_s & scl_q & sda_q & ~sda_s;
    assign stop     = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/ptr_reg_slave.sv
module ptr_reg_slave
    import smb_ptr_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR    = 7'b0101110,
    parameter int         SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe,
    output logic              reg_wr_en,
    output logic [BYTE_W-1:0] reg_wr_addr,
    output logic [BYTE_W-1:0] reg_wr_data,
    output logic [BYTE_W-1:0] reg_rd_addr,
    input  logic [BYTE_W-1:0] reg_rd_data
);
    localparam logic [2:0] LAST_BIT = 3'(BYTE_W - 1);

    logic sda_s, scl_rise, scl_fall, start, stop;
    fsm_s s_d, s_q;

    smb_cond_det #(.SYNC_STAGES(SYNC_STAGES)) cond_i (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start(start), .stop(stop)
    );

    always_comb begin
        s_d       = s_q;
        s_d.wr_en = 1'b0;
        if (stop) begin
            s_d.st = ST_IDLE;
            s_d.oe = 1'b0;
        end else if (start) begin
            s_d.st     = ST_ADDR;
            s_d.bitcnt = '0;
            s_d.oe     = 1'b0;
            s_d.idx    = '0;
        end else begin
            unique case (s_q.st)
                ST_IDLE: ;
                ST_ADDR, ST_DATA: begin
                    if (scl_rise) begin
                        s_d.shreg = {s_q.shreg[BYTE_W-2:0], sda_s};
                        if (s_q.bitcnt == LAST_BIT)
                            s_d.st = (s_q.st == ST_ADDR) ? ST_ADDR_CHK : ST_DATA_END;
                        else
                            s_d.bitcnt = s_q.bitcnt + 3'd1;
                    end
                end
                ST_ADDR_CHK: begin
                    if (scl_fall) begin
                        if (s_q.shreg[BYTE_W-1:1] == DEV_ADDR) begin
                            s_d.rw = s_q.shreg[0];
                            s_d.oe = 1'b1;
                            s_d.st = ST_ACK_A;
                        end else begin
                            s_d.st = ST_IDLE;
                        end
                    end
                end
                ST_ACK_A: begin
                    if (scl_fall) begin
                        s_d.bitcnt = '0;
                        if (s_q.rw) begin
                            s_d.shreg = reg_rd_data;
                            s_d.oe    = ~reg_rd_data[BYTE_W-1];
                            s_d.st    = ST_TX;
                        end else begin
                            s_d.oe  = 1'b0;
                            s_d.idx = '0;
                            s_d.st  = ST_DATA;
                        end
                    end
                end
                ST_DATA_END: begin
                    if (scl_fall) begin
                        s_d.oe = 1'b1;
                        s_d.st = ST_ACK_D;
                        if (s_q.idx == 2'd0) begin
                            s_d.ptr = s_q.shreg;
                        end else if (s_q.idx == 2'd1) begin
                            s_d.wr_en   = 1'b1;
                            s_d.wr_data = s_q.shreg;
                        end
                        if (s_q.idx != 2'd2) s_d.idx = s_q.idx + 2'd1;
                    end
                end
                ST_ACK_D: begin
                    if (scl_fall) begin
                        s_d.oe     = 1'b0;
                        s_d.bitcnt = '0;
                        s_d.st     = ST_DATA;
                    end
                end
                ST_TX: begin
                    if (scl_rise) begin
                        if (s_q.bitcnt == LAST_BIT) s_d.st = ST_TX_END;
                        else                        s_d.bitcnt = s_q.bitcnt + 3'd1;
                    end else if (scl_fall) begin
                        s_d.shreg = {s_q.shreg[BYTE_W-2:0], 1'b0};
                        s_d.oe    = ~s_q.shreg[BYTE_W-2];
                    end
                end
                ST_TX_END: begin
                    if (scl_fall) begin
                        s_d.oe = 1'b0;
                        s_d.st = ST_MACK;
                    end
                end
                ST_MACK: begin
                    if (scl_rise) s_d.st = sda_s ? ST_IDLE : ST_RELOAD;
                end
                ST_RELOAD: begin
                    if (scl_fall) begin
                        s_d.shreg  = reg_rd_data;
                        s_d.oe     = ~reg_rd_data[BYTE_W-1];
                        s_d.bitcnt = '0;
                        s_d.st     = ST_TX;
                    end
                end
                default: s_d.st = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q         <= '0;
            s_q.st      <= ST_IDLE;
        end else begin
            s_q <= s_d;
        end
    end

    assign sda_oe      = s_q.oe;
    assign reg_wr_en   = s_q.wr_en;
    assign reg_wr_addr = s_q.ptr;
    assign reg_wr_data = s_q.wr_data;
    assign reg_rd_addr = s_q.ptr;
endmodule

// File: rtl/ptr_reg_slave_chk.sv
module ptr_reg_slave_chk (
    input logic clk,
    input logic rst_n,
    input logic scl_fall,
    input logic start,
    input logic stop,
    input logic sda_oe,
    input logic reg_wr_en
);
    AST_OE_CHANGES_AFTER_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe) |-> $past(scl_fall || start || stop)); // R9

    AST_STOP_RELEASES_SDA: assert property (@(posedge clk) disable iff (!rst_n)
        stop |=> !sda_oe); // R10

    AST_START_RELEASES_SDA: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> !sda_oe); // R10

    AST_WRITE_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr_en |=> !reg_wr_en); // R4

    AST_WRITE_AFTER_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr_en |-> $past(scl_fall)); // R4
endmodule

bind ptr_reg_slave ptr_reg_slave_chk chk_i (
    .clk(clk), .rst_n(rst_n), .scl_fall(scl_fall), .start(start),
    .stop(stop), .sda_oe(sda_oe), .reg_wr_en(reg_wr_en)
);

// File: tb/ptr_reg_slave_tb_top.sv
module ptr_reg_slave_tb_top;
    localparam int Q = 10;
    localparam logic [6:0] DEV = 7'b0101110;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic rst_n = 1'b0;
    logic scl = 1'b1, sda_m = 1'b1;
    logic sda_oe, reg_wr_en;
    logic [7:0] reg_wr_addr, reg_wr_data, reg_rd_addr, reg_rd_data;
    logic line;
    assign line = sda_m & ~sda_oe;

    logic [7:0] regs [256];
    int wr_cnt = 0;
    logic [7:0] last_a = 8'h00, last_d = 8'h00;
    int tests = 0, fails = 0;

    assign reg_rd_data = regs[reg_rd_addr];

    always @(posedge clk) begin
        if (reg_wr_en) begin
            regs[reg_wr_addr] <= reg_wr_data;
            wr_cnt <= wr_cnt + 1;
            last_a <= reg_wr_addr;
            last_d <= reg_wr_data;
        end
    end

    ptr_reg_slave dut_i (
        .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(line), .sda_oe(sda_oe),
        .reg_wr_en(reg_wr_en), .reg_wr_addr(reg_wr_addr), .reg_wr_data(reg_wr_data),
        .reg_rd_addr(reg_rd_addr), .reg_rd_data(reg_rd_data)
    );

    task automatic wq(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input logic ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic bus_start();
        sda_m = 1'b1; wq(Q);
        scl = 1'b1;   wq(Q);
        sda_m = 1'b0; wq(Q);
        scl = 1'b0;   wq(Q);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wq(Q);
        scl = 1'b1;   wq(Q);
        sda_m = 1'b1; wq(2*Q);
    endtask

    task automatic clk_bit(input logic b, output logic s0, output logic s1);
        sda_m = b; wq(Q);
        scl = 1'b1; wq(1);
        s0 = line; wq(Q);
        s1 = line; wq(Q-1);
        scl = 1'b0; wq(Q);
    endtask

    task automatic send_bits(input logic [7:0] b, input int n);
        logic s0, s1;
        for (int i = 7; i > 7 - n; i--) clk_bit(b[i], s0, s1);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        logic s0, s1;
        send_bits(b, 8);
        clk_bit(1'b1, s0, s1);
        ack = ~s1;
    endtask

    task automatic read_byte(input logic m_ack, output logic [7:0] d, output logic stable);
        logic s0, s1;
        stable = 1'b1;
        for (int i = 0; i < 8; i++) begin
            clk_bit(1'b1, s0, s1);
            d = {d[6:0], s1};
            if (s0 != s1) stable = 1'b0;
        end
        clk_bit(~m_ack, s0, s1);
    endtask

    task automatic t_reset();
        wq(5);
        chk(sda_oe == 1'b0, "R11 sda_oe", int'(sda_oe), 0);
        chk(reg_wr_en == 1'b0, "R11 reg_wr_en", int'(reg_wr_en), 0);
        chk(reg_rd_addr == 8'h00, "R11 pointer", int'(reg_rd_addr), 0);
    endtask

    task automatic t_write_two();
        logic ack; int c0;
        c0 = wr_cnt;
        bus_start();
        send_byte({DEV, 1'b0}, ack); chk(ack, "R1 address ack", int'(ack), 1);
        send_byte(8'h05, ack);       chk(ack, "R3 pointer byte ack", int'(ack), 1);
        chk(reg_rd_addr == 8'h05, "R3 pointer loaded", int'(reg_rd_addr), 5);
        send_byte(8'hA7, ack);       chk(ack, "R4 data byte ack", int'(ack), 1);
        bus_stop();
        chk(wr_cnt == c0 + 1, "R4 one write", wr_cnt - c0, 1);
        chk(last_a == 8'h05, "R4 write address", int'(last_a), 5);
        chk(last_d == 8'hA7, "R4 write data", int'(last_d), 'hA7);
    endtask

    task automatic t_ptr_only();
        logic ack; int c0;
        c0 = wr_cnt;
        bus_start();
        send_byte({DEV, 1'b0}, ack);
        send_byte(8'h0C, ack); chk(ack, "R5 pointer ack", int'(ack), 1);
        bus_stop();
        chk(reg_rd_addr == 8'h0C, "R5 pointer updated", int'(reg_rd_addr), 'h0C);
        chk(wr_cnt == c0, "R5 no write", wr_cnt - c0, 0);
    endtask

    task automatic t_read(input logic [7:0] p);
        logic ack, st; logic [7:0] d; logic [7:0] exp;
        exp = regs[p];
        bus_start();
        send_byte({DEV, 1'b0}, ack);
        send_byte(p, ack);
        bus_start();
        send_byte({DEV, 1'b1}, ack); chk(ack, "R1 read address ack", int'(ack), 1);
        read_byte(1'b0, d, st);
        chk(d == exp, "R7 read data", int'(d), int'(exp));
        chk(st, "R9 SDA stable while SCL high", int'(st), 1);
        wq(Q);
        chk(sda_oe == 1'b0, "R8 released after NACK", int'(sda_oe), 0);
        bus_stop();
        chk(sda_oe == 1'b0, "R8 idle after STOP", int'(sda_oe), 0);
    endtask

    task automatic t_read_repeat();
        logic ack, st; logic [7:0] d1, d2, exp;
        exp = regs[8'h10];
        bus_start();
        send_byte({DEV, 1'b0}, ack);
        send_byte(8'h10, ack);
        bus_start();
        send_byte({DEV, 1'b1}, ack);
        read_byte(1'b1, d1, st);
        read_byte(1'b0, d2, st);
        bus_stop();
        chk(d1 == exp, "R7 first read byte", int'(d1), int'(exp));
        chk(d2 == exp, "R8 repeated byte same register", int'(d2), int'(exp));
        chk(reg_rd_addr == 8'h10, "R8 no auto-increment", int'(reg_rd_addr), 'h10);
    endtask

    task automatic t_extra();
        logic ack; int c0;
        c0 = wr_cnt;
        bus_start();
        send_byte({DEV, 1'b0}, ack);
        send_byte(8'h03, ack);
        send_byte(8'h11, ack);
        send_byte(8'h22, ack); chk(ack, "R6 third byte acked", int'(ack), 1);
        send_byte(8'h33, ack); chk(ack, "R6 fourth byte acked", int'(ack), 1);
        bus_stop();
        chk(wr_cnt == c0 + 1, "R6 single write", wr_cnt - c0, 1);
        chk(regs[8'h03] == 8'h11, "R6 register keeps second byte", int'(regs[8'h03]), 'h11);
        chk(reg_rd_addr == 8'h03, "R6 pointer unchanged", int'(reg_rd_addr), 3);
    endtask

    task automatic t_mismatch();
        logic ack; int c0; logic [7:0] p0;
        c0 = wr_cnt; p0 = reg_rd_addr;
        bus_start();
        send_byte({7'h2F, 1'b0}, ack); chk(!ack, "R2 no ack on wrong address", int'(ack), 0);
        send_byte(8'h09, ack);         chk(!ack, "R2 no ack on data", int'(ack), 0);
        send_byte(8'h44, ack);         chk(!ack, "R2 no ack on second data", int'(ack), 0);
        bus_stop();
        chk(reg_rd_addr == p0, "R2 pointer untouched", int'(reg_rd_addr), int'(p0));
        chk(wr_cnt == c0, "R2 no write", wr_cnt - c0, 0);
    endtask

    task automatic t_abort();
        logic ack; int c0;
        c0 = wr_cnt;
        bus_start();
        send_byte({DEV, 1'b0}, ack);
        send_byte(8'h20, ack);
        send_bits(8'hF0, 4);
        bus_stop();
        chk(wr_cnt == c0, "R10 partial byte no write", wr_cnt - c0, 0);
        chk(sda_oe == 1'b0, "R10 STOP releases", int'(sda_oe), 0);
        bus_start();
        send_bits({DEV, 1'b0}, 3);
        bus_start();
        send_byte({DEV, 1'b0}, ack); chk(ack, "R10 address after restart", int'(ack), 1);
        send_byte(8'h21, ack);
        send_byte(8'h5A, ack);
        bus_stop();
        chk(wr_cnt == c0 + 1 && last_a == 8'h21 && last_d == 8'h5A,
            "R10 write after restart", int'(last_d), 'h5A);
    endtask

    initial begin
        for (int i = 0; i < 256; i++) regs[i] = 8'(i * 7 + 3);
    end

    initial begin
        wq(4);
        rst_n = 1'b1;
        t_reset();
        t_write_two();
        t_ptr_only();
        t_read(8'h05);
        t_read(8'h0C);
        t_read_repeat();
        t_extra();
        t_mismatch();
        t_abort();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        tests++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule